// File: doc/BRIEF.md
# Endpoint Memory Window Decode and Request Gate

This block sits on the receive side of a single-function endpoint and decides, request by request, whether the function takes the request. It holds a small configuration set: a read-only identity word, a command word with three writable enables, and one 32-bit memory base register. Configuration reads and writes are always taken, so that a host can discover and program the function before anything else works.

A host discovers the function by reading offset 0x00 and then sizes the window. It writes all ones to the base register and reads it back: the cleared low bits give the window size. It then writes a real base and sets the memory enable. From then on a memory request is accepted only when its address lands inside the programmed window. A separate bus-master enable output tells the function's own requester that it may issue memory traffic.

The window size is the parameter `WIN_BYTES`. It must be a power of two and at least 16. The identity word comes from `VENDOR_ID` and `DEVICE_ID`, and `VENDOR_ID` must not be 16'hFFFF.

Top module: `ep_bar_gate`

## Requirements
- R1: Every configuration read or write is acknowledged on `cfg_ack` in the same cycle it is presented, whatever the command and base state, including straight after reset.
- R2: Reading offset 0x00 returns `{DEVICE_ID, VENDOR_ID}` with the low 16 bits not equal to 16'hFFFF, and writes to offset 0x00 change nothing.
- R3: Offset 0x04 holds the command word: bit 0 is the I/O enable, bit 1 the memory enable and bit 2 the bus-master enable. All three are writable, every other bit reads zero, and all three are zero after reset.
- R4: Offset 0x10 is the memory base register. Address bits at and above log2(`WIN_BYTES`) are writable. Bits below that position always read zero, so bits [3:0] report a 32-bit non-prefetchable memory window. Writing 32'hFFFFFFFF reads back as ~(`WIN_BYTES`-1), and the base bits are zero after reset.
- R5: `mem_accept` is high in the same cycle as `mem_valid` when the memory enable is set and `mem_addr[31:log2(WIN_BYTES)]` equals the stored base bits. The address bits below that position are not compared.
- R6: When the memory enable is clear, no memory request is accepted, even if its address matches the base.
- R7: `mem_reject` equals `mem_valid` and not `mem_accept`. The two outputs are never high together, and both are low when `mem_valid` is low.
- R8: `bus_master_en` equals command bit 2, and changes on the clock edge that completes a command write.
- R9: Reads of any offset other than 0x00, 0x04 and 0x10 return zero, and writes to such offsets leave all registers unchanged.
- R10: A configuration write takes effect at the clock edge on which it is presented. Reads and memory decisions are combinational on the current register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (bits [1:0] ignored) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_ack | output | 1 | Configuration request taken |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| mem_valid | input | 1 | Memory request present |
| mem_addr | input | 32 | Memory request byte address |
| mem_accept | output | 1 | Memory request accepted |
| mem_reject | output | 1 | Memory request rejected |
| bus_master_en | output | 1 | Function may issue memory requests |

## Verification
A corrupted base register shows up at once in two places. The next read of offset 0x10 returns the wrong value, and an in-window address is refused while an out-of-window address is taken in the same cycle it is presented. A lost or stuck command bit shows as acceptance that ignores the memory enable, or as a `bus_master_en` that disagrees with the command read-back one cycle after the write. Because every read and decision is combinational, any bad state is visible on the first request after the faulty edge. The bench therefore compares every read and every memory decision against its own register model.

// File: rtl/ep_bar_gate.sv
module ep_bar_gate #(
  parameter logic [15:0] VENDOR_ID = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID = 16'h0C3D,
  parameter int unsigned WIN_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_rd,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        cfg_ack,
  output logic [31:0] cfg_rdata,
  input  logic        mem_valid,
  input  logic [31:0] mem_addr,
  output logic        mem_accept,
  output logic        mem_reject,
  output logic        bus_master_en
);
  localparam int AW = $clog2(WIN_BYTES);
  localparam int BW = 32 - AW;
  localparam logic [5:0] DW_ID  = 6'd0;
  localparam logic [5:0] DW_CMD = 6'd1;
  localparam logic [5:0] DW_BAR = 6'd4;

  logic [2:0]    cmd_q;
  logic [BW-1:0] base_q;
  logic [5:0]    dw;
  logic          hit;

  assign dw = cfg_addr[7:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      base_q <= '0;
    end else if (cfg_wr) begin
      if (dw == DW_CMD) cmd_q  <= cfg_wdata[2:0];
      if (dw == DW_BAR) base_q <= cfg_wdata[31:AW];
    end
  end

  always_comb begin
    case (dw)
      DW_ID:   cfg_rdata = {DEVICE_ID, VENDOR_ID};
      DW_CMD:  cfg_rdata = {29'd0, cmd_q};
      DW_BAR:  cfg_rdata = {base_q, {AW{1'b0}}};
      default: cfg_rdata = '0;
    endcase
  end

  assign cfg_ack       = cfg_rd | cfg_wr;
  assign hit           = mem_addr[31:AW] == base_q;
  assign mem_accept    = mem_valid & cmd_q[1] & hit;
  assign mem_reject    = mem_valid & ~mem_accept;
  assign bus_master_en = cmd_q[2];
endmodule

module ep_bar_gate_chk #(
  parameter int unsigned WIN_BYTES = 4096
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_rd,
  input logic        cfg_wr,
  input logic [7:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        cfg_ack,
  input logic [31:0] cfg_rdata,
  input logic        mem_valid,
  input logic        mem_accept,
  input logic        mem_reject,
  input logic        bus_master_en,
  input logic [2:0]  cmd_q
);
  localparam int AW = $clog2(WIN_BYTES);

  a_r1_cfg_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr) |-> cfg_ack);

  a_r2_vendor_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr[7:2] == 6'd0) |-> cfg_rdata[15:0] != 16'hFFFF);

  a_r4_bar_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr[7:2] == 6'd4) |-> cfg_rdata[AW-1:0] == '0);

  a_r6_mem_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[1] |-> !mem_accept);

  a_r7_accept_reject_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_accept, mem_reject}) && (mem_valid == (mem_accept || mem_reject)));

  a_r8_bm_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr[7:2] == 6'd1) |=> bus_master_en == $past(cfg_wdata[2]));

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr[7:2] != 6'd0 && cfg_addr[7:2] != 6'd1 && cfg_addr[7:2] != 6'd4)
      |-> cfg_rdata == 32'd0);
endmodule

bind ep_bar_gate ep_bar_gate_chk #(.WIN_BYTES(WIN_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
  .mem_valid(mem_valid), .mem_accept(mem_accept), .mem_reject(mem_reject),
  .bus_master_en(bus_master_en), .cmd_q(cmd_q)
);

// File: tb/tb_ep_bar_gate.sv
module tb_ep_bar_gate;
  localparam logic [15:0] VID = 16'h1A2B;
  localparam logic [15:0] DID = 16'h0C3D;
  localparam int WIN = 4096;
  localparam int AW  = $clog2(WIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rd = 1'b0, cfg_wr = 1'b0, mem_valid = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, mem_addr = '0;
  logic cfg_ack, mem_accept, mem_reject, bus_master_en;
  logic [31:0] cfg_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0]     m_cmd  = '0;
  logic [31-AW:0] m_base = '0;

  always #10 clk = ~clk;

  ep_bar_gate #(.VENDOR_ID(VID), .DEVICE_ID(DID), .WIN_BYTES(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_accept(mem_accept),
    .mem_reject(mem_reject), .bus_master_en(bus_master_en));

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a[7:2])
      6'd0:    return {DID, VID};
      6'd1:    return {29'd0, m_cmd};
      6'd4:    return {m_base, {AW{1'b0}}};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_acc(input logic [31:0] a);
    return m_cmd[1] && (a[31:AW] == m_base);
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cfg_rd = 0; cfg_wr = 0; mem_valid = 0;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    idle(); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    #5 cmp("R1 write ack", {31'd0, cfg_ack}, 32'd1);
    @(posedge clk);
    if (a[7:2] == 6'd1) m_cmd = d[2:0];
    if (a[7:2] == 6'd4) m_base = d[31:AW];
    #1;
    cmp("R8 bus master enable", {31'd0, bus_master_en}, {31'd0, m_cmd[2]});
  endtask

  task automatic cfg_read(input logic [7:0] a, input string req);
    @(negedge clk);
    idle(); cfg_rd = 1; cfg_addr = a;
    #5 cmp("R1 read ack", {31'd0, cfg_ack}, 32'd1);
    cmp(req, cfg_rdata, exp_rd(a));
  endtask

  task automatic mem_req(input logic [31:0] a, input string req);
    logic e;
    @(negedge clk);
    idle(); mem_valid = 1; mem_addr = a;
    e = exp_acc(a);
    #5 cmp(req, {30'd0, mem_accept, mem_reject}, {30'd0, e, ~e});
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3/R4 reset state, R1 before any programming
    cfg_read(8'h04, "R3 command reset value");
    cfg_read(8'h10, "R4 base reset value");
    cfg_read(8'h00, "R2 identity word");
    n_cmp++;
    if (cfg_rdata[15:0] == 16'hFFFF) begin
      n_bad++; $display("FAIL R2 vendor all ones actual=%h expected=not ffff", cfg_rdata[15:0]);
    end
    // R6 address 0 matches reset base but memory enable is clear
    mem_req(32'h0000_0010, "R6 reset base without enable");
    @(negedge clk); idle();
    #5 cmp("R7 idle outputs low", {30'd0, mem_accept, mem_reject}, 32'd0);
    // R4 sizing probe
    cfg_write(8'h10, 32'hFFFF_FFFF);
    cfg_read(8'h10, "R4 sizing mask");
    cmp("R4 sizing mask literal", cfg_rdata, ~(WIN - 1));
    cfg_write(8'h10, 32'h8000_5ABC);
    cfg_read(8'h10, "R4 base programmed low bits dropped");
    // R2 write ignored, R9 unmapped
    cfg_write(8'h00, 32'h1234_5678);
    cfg_read(8'h00, "R2 write ignored");
    cfg_write(8'h08, 32'hFFFF_FFFF);
    cfg_write(8'h3C, 32'hFFFF_FFFF);
    cfg_read(8'h08, "R9 unmapped read zero");
    cfg_read(8'h10, "R9 base untouched by unmapped write");
    cfg_read(8'h04, "R9 command untouched by unmapped write");
    // R6 matching address, memory disabled but others set
    cfg_write(8'h04, 32'hFFFF_FFFD);
    cfg_read(8'h04, "R3 other bits read zero");
    mem_req(32'h8000_5000, "R6 match with memory enable clear");
    // R5 enabled, edges of window
    cfg_write(8'h04, 32'h0000_0002);
    mem_req(32'h8000_5000, "R5 window first byte");
    mem_req(32'h8000_5FFF, "R5 window last byte");
    mem_req(32'h8000_4FFF, "R5 just below window");
    mem_req(32'h8000_6000, "R5 just above window");
    // R10 write takes effect at its own edge: request right after
    cfg_write(8'h10, 32'h0000_1000);
    mem_req(32'h0000_1800, "R10 new base in effect");
    mem_req(32'h8000_5000, "R10 old base gone");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k == 0) cfg_write(8'h04, $urandom);
      else if (k == 1) cfg_write(8'h10, ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom);
      else if (k == 2) cfg_write({$urandom_range(0, 63), 2'b00}, $urandom);
      else if (k <= 4) cfg_read({$urandom_range(0, 7), 2'($urandom)}, "R2 R3 R4 R9 random read");
      else if (k <= 7) mem_req({m_base, AW'($urandom)}, "R5 R6 random in-window request");
      else mem_req($urandom, "R5 R7 random request");
    end
    @(negedge clk); idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule